// File: doc/BRIEF.md
# Inter-processor doorbell mailbox

This block lets any processor in a small cluster ring a doorbell on any other processor and pass it a 16-bit payload. Every processor has a pair of 32-bit registers, a command word and a mailbox word, reached over a plain single-cycle register bus. Writing the command word can post a message into another processor's mailbox word and raise that processor's interrupt. The same write can also clear the writer's own pending message and drop its own interrupt.

The sender is never written into the message by software. The block takes the sender's number from the register window the write went through. It records that number in the receiver's mailbox word next to the payload, so the receiver can see who rang. There is one message slot per processor. A new message overwrites an older one that has not been cleared yet. The bus has no wait states: a write takes effect at the clock edge on which it is presented, and read data is combinational from the selected register in the same cycle. The bus has no back-pressure, so every access completes in the cycle it is presented.

`MAX_PROCS` sets how many register windows are decoded. `NUM_PROCS` sets how many of them are live. Its default is 1.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset every command word and every mailbox word reads 0, and every `irq` bit is 0.
- R2: `bus_addr` carries byte-address bits from bit 2 upward. Port bit 0 (byte bit 2) selects the register: 0 is the command word and 1 is the mailbox word. The upper port bits select the processor window. A write to a command word stores all 32 bits, and a read returns that value.
- R3: Writes to a mailbox word change nothing, in any register and on `irq`.
- R4: A command write with bit 30 set posts to the processor numbered in bits 29:16. That target's mailbox word becomes: bit 30 = 1, bits 29:16 = the writer's window number, bits 15:0 = the written bits 15:0, and bit 31 = 0. Any earlier content is overwritten.
- R5: Each `irq` bit is a registered level equal to the pending bit (bit 30) of that processor's mailbox word. It rises in the cycle after the posting write.
- R6: A command write with bit 31 set clears bit 30 of the writer's own mailbox word and lowers its `irq`. Bits 29:16 and 15:0 of that mailbox word are kept.
- R7: When one write sets both bit 30 and bit 31, the post is applied first and the clear second. A processor that posts to itself in such a write ends with its pending bit clear. A processor that posts to another processor in such a write leaves the target pending and itself cleared.
- R8: A post whose target number is at or above `NUM_PROCS` changes no mailbox word and no `irq`. The command word is still stored.
- R9: Windows numbered at or above `NUM_PROCS` read as 0, and writes to them have no effect on any register or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | IDX_W+1 | Byte-address bits from bit 2 upward: bit 0 selects the register, the upper bits select the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when there is no read or the window is not live |
| irq | output | MAX_PROCS | One interrupt level per processor |

## Verification
The hardest cases to reach are the ones where a single write acts on two mailboxes at once, or acts twice on the same mailbox. Examples are a processor posting to itself while clearing, or a processor clearing its own message while it posts to a neighbour. The bench reaches them by first leaving a processor with a pending message from another sender. It then has that processor issue a combined post-and-clear command. The bench reads back both mailbox words and the whole `irq` vector, so it sees both the order of the two actions and the fields that were kept.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
  localparam int WORD_W  = 32;
  localparam int ACK_BIT = 31;
  localparam int GEN_BIT = 30;
  localparam int TGT_LO  = 16;
  localparam int TGT_W   = 14;
  localparam int PAY_W   = 16;

  // Mailbox word: pending flag, sender number, payload.
  function automatic logic [WORD_W-1:0] make_mail(input logic [TGT_W-1:0] src,
                                                  input logic [PAY_W-1:0] pay);
    return {1'b0, 1'b1, src, pay};
  endfunction
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode #(
  parameter int IDX_W     = 2,
  parameter int NUM_PROCS = 1
) (
  input  logic [IDX_W:0]   addr,
  output logic [IDX_W-1:0] idx,
  output logic             is_mail,
  output logic             in_range
);
  assign is_mail  = addr[0];
  assign idx      = addr[IDX_W:1];
  assign in_range = (int'(idx) < NUM_PROCS);
endmodule

// File: rtl/ipi_proc_slot.sv
module ipi_proc_slot
  import ipi_mbox_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] mail_q,
  output logic              irq_q
);
  logic [TGT_W-1:0]  src_ext;
  logic              own_wr, post_hit, clr_hit;
  logic [WORD_W-1:0] mail_d;

  assign src_ext  = TGT_W'(src_idx);
  assign own_wr   = cmd_wr && (src_idx == IDX_W'(IDX));
  assign post_hit = cmd_wr && wdata[GEN_BIT] &&
                    (wdata[TGT_LO +: TGT_W] == TGT_W'(IDX));
  assign clr_hit  = own_wr && wdata[ACK_BIT];

  // Post first, then clear.
  always_comb begin
    mail_d = mail_q;
    if (post_hit) mail_d = make_mail(src_ext, wdata[PAY_W-1:0]);
    if (clr_hit)  mail_d[GEN_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mail_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (own_wr) cmd_q <= wdata;
      mail_q <= mail_d;
      irq_q  <= mail_d[GEN_BIT];
    end
  end

  p_cmd_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    own_wr |=> cmd_q == $past(wdata));

  p_mail_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(mail_q) && $stable(irq_q));

  p_post_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    post_hit && !clr_hit |=> mail_q[GEN_BIT] && irq_q &&
      mail_q[PAY_W-1:0] == $past(wdata[PAY_W-1:0]) &&
      mail_q[TGT_LO +: TGT_W] == $past(src_ext));

  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == mail_q[GEN_BIT]);

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !mail_q[GEN_BIT] && !irq_q);

  p_clear_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && !post_hit |=> mail_q[29:0] == $past(mail_q[29:0]));
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_mbox_pkg::*;
#(
  parameter int MAX_PROCS = 4,
  parameter int NUM_PROCS = 1,
  localparam int IDX_W = (MAX_PROCS > 1) ? $clog2(MAX_PROCS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [IDX_W:0]       bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [MAX_PROCS-1:0] irq
);
  logic [IDX_W-1:0]  idx;
  logic              is_mail, in_range, cmd_wr;
  logic [WORD_W-1:0] cmd_arr  [MAX_PROCS];
  logic [WORD_W-1:0] mail_arr [MAX_PROCS];

  ipi_addr_decode #(.IDX_W(IDX_W), .NUM_PROCS(NUM_PROCS)) u_dec (
    .addr(bus_addr), .idx(idx), .is_mail(is_mail), .in_range(in_range)
  );

  assign cmd_wr = bus_sel && bus_wr && !is_mail && in_range;

  for (genvar g = 0; g < MAX_PROCS; g++) begin : g_slot
    if (g < NUM_PROCS) begin : g_live
      ipi_proc_slot #(.IDX(g), .IDX_W(IDX_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .src_idx(idx),
        .wdata(bus_wdata), .cmd_q(cmd_arr[g]), .mail_q(mail_arr[g]),
        .irq_q(irq[g])
      );
    end else begin : g_dead
      assign cmd_arr[g]  = '0;
      assign mail_arr[g] = '0;
      assign irq[g]      = 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && in_range)
      bus_rdata = is_mail ? mail_arr[idx] : cmd_arr[idx];
  end

  p_dead_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !in_range |-> bus_rdata == '0);

  p_dead_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq >> NUM_PROCS) == '0);
endmodule

// File: tb/ipi_mailbox_bench.sv
module ipi_mailbox_bench;
  localparam int MAXP = 4;
  localparam int NUMP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ipi_mailbox #(.MAX_PROCS(MAXP), .NUM_PROCS(NUMP)) u_ipi_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int p, input bit mail, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = {2'(p), mail}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input int p, input bit mail, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = {2'(p), mail};
    #5 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  function automatic logic [31:0] post(input int tgt, input logic [15:0] pay);
    return 32'h4000_0000 | (32'(tgt) << 16) | 32'(pay);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    for (int p = 0; p < MAXP; p++) begin
      rd(p, 0, v); check("R1 cmd", v, 0);
      rd(p, 1, v); check("R1 mail", v, 0);
    end
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_cmd_store();
    logic [31:0] v;
    wr(1, 0, 32'h1234_5678);
    rd(1, 0, v); check("R2 cmd readback", v, 32'h1234_5678);
    rd(0, 0, v); check("R2 other window", v, 0);
    rd(1, 1, v); check("R2 mail untouched", v, 0);
  endtask

  task automatic t_mail_ro();
    logic [31:0] v;
    wr(2, 1, 32'hFFFF_FFFF);
    rd(2, 1, v); check("R3 mail write ignored", v, 0);
    check("R3 irq", 32'(irq), 0);
  endtask

  task automatic t_post();
    logic [31:0] v;
    wr(0, 0, post(2, 16'hBEEF));
    check("R5 irq after post", 32'(irq), 32'b0100);
    rd(2, 1, v); check("R4 mail fields", v, 32'h4000_BEEF);
    wr(1, 0, post(2, 16'h1111));
    rd(2, 1, v); check("R4 overwrite", v, 32'h4001_1111);
    check("R5 irq held", 32'(irq), 32'b0100);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(2, 0, 32'h8000_0000);
    check("R6 irq low", 32'(irq), 0);
    rd(2, 1, v); check("R6 fields kept", v, 32'h0001_1111);
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(1, 0, 32'hC000_0000 | (32'd1 << 16) | 32'h00AA);
    rd(1, 1, v); check("R7 self post+clear", v, 32'h0001_00AA);
    check("R7 self irq", 32'(irq), 0);
    wr(0, 0, post(1, 16'h5555));
    check("R7 setup irq", 32'(irq), 32'b0010);
    wr(1, 0, 32'hC000_0000 | (32'd2 << 16) | 32'h0077);
    rd(2, 1, v); check("R7 target pending", v, 32'h4001_0077);
    rd(1, 1, v); check("R7 writer cleared", v, 32'h0000_5555);
    check("R7 irq", 32'(irq), 32'b0100);
  endtask

  task automatic t_bad_target();
    logic [31:0] v;
    wr(0, 0, post(3, 16'h0009));
    rd(0, 0, v); check("R8 cmd stored", v, post(3, 16'h0009));
    check("R8 irq", 32'(irq), 32'b0100);
    wr(0, 0, post(100, 16'h0009));
    for (int p = 0; p < NUMP; p++) begin
      rd(p, 1, v);
      check("R8 mail unchanged", v, (p == 0) ? 32'h0 : (p == 1) ? 32'h0000_5555 : 32'h4001_0077);
    end
    check("R8 irq after far target", 32'(irq), 32'b0100);
  endtask

  task automatic t_dead_window();
    logic [31:0] v;
    wr(3, 0, post(0, 16'h0ABC));
    rd(3, 0, v); check("R9 dead cmd", v, 0);
    rd(3, 1, v); check("R9 dead mail", v, 0);
    rd(0, 1, v); check("R9 no post", v, 0);
    check("R9 irq", 32'(irq), 32'b0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cmd_store();
    t_mail_ro();
    t_post();
    t_ack();
    t_both();
    t_bad_target();
    t_dead_window();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule